// File: doc/BRIEF.md
# Fully Associative Cache Bypass Buffer

This block is a small side store placed next to a set-associative cache. Sometimes a line cannot take a cache way because a protocol-thread access and an application access contend for the same index. Holding that line back could deadlock the pipeline, so the requester writes it into this buffer instead. Each entry keeps a whole line together with its full line-address tag. Any entry can hold any line.

A lookup is compared against every entry in the same cycle the cache tags are read, and the result is purely combinational. A line found here therefore costs no more than a line found in the cache. Replacement follows least-recent use, and both hits and allocations refresh an entry's recency. When every entry is occupied and a new line arrives, the oldest entry is displaced. Its tag and data appear on an eviction port for exactly one cycle, so the owner can write the line back or drop it.

Top module: `fa_bypass_buf`

## Requirements
- R1: With `lk_valid` high and `lk_tag` equal to the tag of a valid entry, `lk_hit` is 1 and `lk_data` equals that entry's data, combinationally in the same cycle.
- R2: With `lk_valid` low or `lk_tag` absent from the buffer, `lk_hit` is 0 and `lk_data` is all zeros. After reset no tag hits and `ev_valid` is 0.
- R3: While fewer than `ENTRIES` (default 16) entries are valid, an allocation of a new tag occupies a free entry and `ev_valid` stays 0 in the following cycle.
- R4: An allocation of a new tag while all entries are valid replaces the least recently used entry. In the cycle after the allocation edge, `ev_valid` is 1 and `ev_tag`/`ev_data` hold the displaced tag and data. `ev_valid` returns to 0 one cycle later unless another replacement occurred.
- R5: A lookup hit makes the hit entry the most recently used, so it becomes the last candidate for replacement.
- R6: An allocation whose tag is already present overwrites that entry's data and makes it most recently used. It creates no second copy and causes no eviction.
- R7: When a lookup and an allocation share a cycle, the lookup returns the contents from before the allocation. The hit entry is refreshed first and the allocated entry becomes most recently used after it. The replacement victim is chosen after the hit's refresh.
- R8: No tag is ever held by more than one valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, empties the buffer |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_tag | input | ADDR_W-log2(LINE_BYTES) | Line address being looked up |
| lk_hit | output | 1 | Lookup found a valid entry (combinational) |
| lk_data | output | LINE_BYTES*8 | Line data of the hit entry, zero on a miss |
| al_valid | input | 1 | Allocation request, applied at the clock edge |
| al_tag | input | ADDR_W-log2(LINE_BYTES) | Line address being allocated |
| al_data | input | LINE_BYTES*8 | Line data to store |
| ev_valid | output | 1 | One-cycle pulse: an entry was displaced |
| ev_tag | output | ADDR_W-log2(LINE_BYTES) | Tag of the displaced entry |
| ev_data | output | LINE_BYTES*8 | Data of the displaced entry |

## Verification
A lookup and an allocation can both act in one cycle. Each one refreshes recency, and they may name the same tag or the entry that is about to be displaced. Directed steps provoke this by looking up the oldest line while a new line is allocated into a full buffer, and by looking up a tag while the same tag is rewritten. Long mixed streams over a tag pool larger than the buffer provoke it further. A queue-based recency model in the bench predicts each outcome: the lookup must return the pre-write data, and the victim must be the line that is oldest once the hit has been refreshed.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int FAB_ENTRIES_DEF    = 16;
    localparam int FAB_LINE_BYTES_DEF = 64;
    localparam int FAB_ADDR_W_DEF     = 32;

    // What an allocation request does to the store this cycle
    typedef enum logic [1:0] {
        AL_IDLE    = 2'd0,
        AL_UPDATE  = 2'd1,
        AL_FILL    = 2'd2,
        AL_REPLACE = 2'd3
    } alloc_kind_e;

    function automatic alloc_kind_e classify(input logic req, input logic present, input logic full);
        if (!req)         return AL_IDLE;
        else if (present) return AL_UPDATE;
        else if (!full)   return AL_FILL;
        else              return AL_REPLACE;
    endfunction

endpackage

// File: rtl/fab_match.sv
module fab_match #(
    parameter int N  = fab_pkg::FAB_ENTRIES_DEF,
    parameter int TW = 26,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [TW-1:0]         key,
    input  logic [N-1:0]          valid_vec,
    input  logic [N-1:0][TW-1:0]  tag_vec,
    output logic [N-1:0]          hit_vec,
    output logic                  hit,
    output logic [IW-1:0]         idx
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = en && valid_vec[g] && (tag_vec[g] == key);
        end
    endgenerate

    assign hit = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = idx | IW'(i);
        end
    end

    // Uniqueness of stored tags
    assert_unique_tag_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/fab_lru.sv
module fab_lru #(
    parameter int N = fab_pkg::FAB_ENTRIES_DEF,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid_vec,
    input  logic          hit_touch,
    input  logic [IW-1:0] hit_idx,
    input  logic          al_touch,
    input  logic [IW-1:0] al_idx,
    output logic          full,
    output logic [IW-1:0] victim_idx
);

    // Recency rank per entry: 0 = most recent, N-1 = oldest. Always a permutation.
    logic [N-1:0][IW-1:0] rank_q, rank_mid, rank_nxt;

    always_comb begin
        rank_mid = rank_q;
        if (hit_touch) begin
            for (int i = 0; i < N; i++) begin
                if (rank_q[i] < rank_q[hit_idx]) rank_mid[i] = rank_q[i] + 1'b1;
            end
            rank_mid[hit_idx] = '0;
        end
    end

    always_comb begin
        rank_nxt = rank_mid;
        if (al_touch) begin
            for (int i = 0; i < N; i++) begin
                if (rank_mid[i] < rank_mid[al_idx]) rank_nxt[i] = rank_mid[i] + 1'b1;
            end
            rank_nxt[al_idx] = '0;
        end
    end

    assign full = &valid_vec;

    // Victim: lowest free entry, otherwise the oldest after the hit refresh
    always_comb begin
        victim_idx = '0;
        if (!full) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!valid_vec[i]) victim_idx = IW'(i);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (rank_mid[i] == IW'(N - 1)) victim_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else begin
            rank_q <= rank_nxt;
        end
    end

    assert_hit_becomes_mru_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_touch && !al_touch) |=> (rank_q[$past(hit_idx)] == '0));

    assert_alloc_becomes_mru_R7: assert property (@(posedge clk) disable iff (rst)
        al_touch |=> (rank_q[$past(al_idx)] == '0));

endmodule

// File: rtl/fab_store.sv
module fab_store #(
    parameter int N  = fab_pkg::FAB_ENTRIES_DEF,
    parameter int TW = 26,
    parameter int DW = 512,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fab_pkg::alloc_kind_e  wr_kind,
    input  logic [IW-1:0]         wr_idx,
    input  logic [TW-1:0]         wr_tag,
    input  logic [DW-1:0]         wr_data,
    output logic [N-1:0]          valid_q,
    output logic [N-1:0][TW-1:0]  tag_q,
    output logic [N-1:0][DW-1:0]  data_q,
    output logic                  ev_valid,
    output logic [TW-1:0]         ev_tag,
    output logic [DW-1:0]         ev_data
);
    import fab_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            tag_q    <= '0;
            data_q   <= '0;
            ev_valid <= 1'b0;
            ev_tag   <= '0;
            ev_data  <= '0;
        end else begin
            ev_valid <= (wr_kind == AL_REPLACE);
            if (wr_kind == AL_REPLACE) begin
                ev_tag  <= tag_q[wr_idx];
                ev_data <= data_q[wr_idx];
            end
            if (wr_kind != AL_IDLE) begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
                data_q[wr_idx]  <= wr_data;
            end
        end
    end

    assert_replace_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == AL_REPLACE) |-> (&valid_q));

endmodule

// File: rtl/fa_bypass_buf.sv
module fa_bypass_buf #(
    parameter int ENTRIES    = fab_pkg::FAB_ENTRIES_DEF,
    parameter int LINE_BYTES = fab_pkg::FAB_LINE_BYTES_DEF,
    parameter int ADDR_W     = fab_pkg::FAB_ADDR_W_DEF,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TW    = ADDR_W - OFF_W,
    localparam int DW    = LINE_BYTES * 8,
    localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_valid,
    input  logic [TW-1:0] lk_tag,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    input  logic          al_valid,
    input  logic [TW-1:0] al_tag,
    input  logic [DW-1:0] al_data,
    output logic          ev_valid,
    output logic [TW-1:0] ev_tag,
    output logic [DW-1:0] ev_data
);
    import fab_pkg::*;

    logic [ENTRIES-1:0]         valid_q;
    logic [ENTRIES-1:0][TW-1:0] tag_q;
    logic [ENTRIES-1:0][DW-1:0] data_q;

    logic [ENTRIES-1:0] lk_vec, al_vec;
    logic               lk_any, al_present;
    logic [IW-1:0]      lk_idx, al_match_idx, victim_idx, wr_idx;
    logic               full;
    alloc_kind_e        wr_kind;

    fab_match #(.N(ENTRIES), .TW(TW)) u_lk_match (
        .clk(clk), .rst(rst), .en(lk_valid), .key(lk_tag),
        .valid_vec(valid_q), .tag_vec(tag_q),
        .hit_vec(lk_vec), .hit(lk_any), .idx(lk_idx)
    );

    fab_match #(.N(ENTRIES), .TW(TW)) u_al_match (
        .clk(clk), .rst(rst), .en(al_valid), .key(al_tag),
        .valid_vec(valid_q), .tag_vec(tag_q),
        .hit_vec(al_vec), .hit(al_present), .idx(al_match_idx)
    );

    assign wr_kind = classify(al_valid, al_present, full);
    assign wr_idx  = al_present ? al_match_idx : victim_idx;

    fab_lru #(.N(ENTRIES)) u_lru (
        .clk(clk), .rst(rst), .valid_vec(valid_q),
        .hit_touch(lk_any), .hit_idx(lk_idx),
        .al_touch(al_valid), .al_idx(wr_idx),
        .full(full), .victim_idx(victim_idx)
    );

    fab_store #(.N(ENTRIES), .TW(TW), .DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_tag(al_tag), .wr_data(al_data),
        .valid_q(valid_q), .tag_q(tag_q), .data_q(data_q),
        .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_data(ev_data)
    );

    assign lk_hit = lk_any;

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i]) lk_data = lk_data | data_q[i];
        end
    end

    assert_fill_no_evict_R3: assert property (@(posedge clk) disable iff (rst)
        (al_valid && !(&valid_q)) |=> !ev_valid);

    assert_update_no_evict_R6: assert property (@(posedge clk) disable iff (rst)
        (al_valid && al_present) |=> !ev_valid);

    assert_evict_follows_alloc_R4: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> ($past(al_valid) && (ev_tag != $past(al_tag))));

    assert_miss_data_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_data == '0));

endmodule

// File: tb/fa_bypass_buf_test.sv
`timescale 1ns/1ps
module fa_bypass_buf_test;

    localparam int N  = 16;
    localparam int TW = 26;
    localparam int DW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_tag = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;
    logic          al_valid = 1'b0;
    logic [TW-1:0] al_tag = '0;
    logic [DW-1:0] al_data = '0;
    logic          ev_valid;
    logic [TW-1:0] ev_tag;
    logic [DW-1:0] ev_data;

    fa_bypass_buf uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
        .al_valid(al_valid), .al_tag(al_tag), .al_data(al_data),
        .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_data(ev_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Reference: recency-ordered queues, front = most recent
    logic [TW-1:0] mq_tag[$];
    logic [DW-1:0] mq_dat[$];
    logic          exp_ev_v = 1'b0;
    logic [TW-1:0] exp_ev_t = '0;
    logic [DW-1:0] exp_ev_d = '0;
    string         prev_req = "R2";
    int            salt = 1;

    function automatic logic [DW-1:0] mkdata(input logic [TW-1:0] t, input int s);
        logic [31:0] w;
        w = {6'(s), t} ^ (32'(s) << 7);
        return {(DW/32){w}};
    endfunction

    function automatic int mfind(input logic [TW-1:0] t);
        for (int i = 0; i < mq_tag.size(); i++) if (mq_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic check1(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic lv, input logic [TW-1:0] lt,
                        input logic av, input logic [TW-1:0] at);
        int p;
        logic [DW-1:0] ad;
        @(negedge clk);
        check1(prev_req, "ev_valid", DW'(ev_valid), DW'(exp_ev_v));
        if (exp_ev_v) begin
            check1(prev_req, "ev_tag", DW'(ev_tag), DW'(exp_ev_t));
            check1(prev_req, "ev_data", ev_data, exp_ev_d);
        end
        ad = mkdata(at, salt);
        salt++;
        lk_valid = lv; lk_tag = lt; al_valid = av; al_tag = at; al_data = ad;
        #1;
        p = lv ? mfind(lt) : -1;
        check1(req, "lk_hit", DW'(lk_hit), DW'(p >= 0));
        check1(req, "lk_data", lk_data, (p >= 0) ? mq_dat[p] : '0);
        if (p >= 0) begin
            logic [TW-1:0] tt; logic [DW-1:0] dd;
            tt = mq_tag[p]; dd = mq_dat[p];
            mq_tag.delete(p); mq_dat.delete(p);
            mq_tag.push_front(tt); mq_dat.push_front(dd);
        end
        exp_ev_v = 1'b0;
        if (av) begin
            p = mfind(at);
            if (p >= 0) begin
                mq_tag.delete(p); mq_dat.delete(p);
            end else if (mq_tag.size() == N) begin
                exp_ev_v = 1'b1;
                exp_ev_t = mq_tag.pop_back();
                exp_ev_d = mq_dat.pop_back();
            end
            mq_tag.push_front(at); mq_dat.push_front(ad);
        end
        prev_req = req;
        @(posedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: empty after reset
        check1("R2", "reset ev_valid", DW'(ev_valid), '0);
        step("R2", 1'b1, 26'd5, 1'b0, '0);
        step("R2", 1'b1, 26'd0, 1'b0, '0);
        // R3: fill all entries, no evictions
        for (int i = 0; i < N; i++) step("R3", 1'b0, '0, 1'b1, TW'(100 + i));
        // R1: every filled line hits
        for (int i = 0; i < N; i++) step("R1", 1'b1, TW'(100 + i), 1'b0, '0);
        // R5: refresh oldest (100), then allocate new: 101 must go
        step("R5", 1'b1, 26'd100, 1'b0, '0);
        step("R4", 1'b0, '0, 1'b1, 26'd200);
        step("R4", 1'b1, 26'd101, 1'b0, '0);
        step("R5", 1'b1, 26'd100, 1'b0, '0);
        // R6: rewrite present tag, no eviction, new data visible
        step("R6", 1'b0, '0, 1'b1, 26'd103);
        step("R6", 1'b1, 26'd103, 1'b0, '0);
        step("R6", 1'b0, '0, 1'b1, 26'd103);
        // R7: lookup oldest while allocating a new tag into a full buffer
        step("R7", 1'b1, 26'd102, 1'b1, 26'd201);
        step("R7", 1'b1, 26'd104, 1'b1, 26'd104);
        step("R7", 1'b1, 26'd104, 1'b1, 26'd202);
        step("R7", 1'b1, 26'd102, 1'b0, '0);
        // R2: absent tags miss
        step("R2", 1'b1, 26'd999, 1'b0, '0);
        step("R2", 1'b0, 26'd102, 1'b0, '0);
        // R8 and mixed: tag pool larger than the buffer
        for (int i = 0; i < 3000; i++) begin
            step("R8", 1'($urandom % 2), TW'($urandom % 24),
                 1'(($urandom % 3) != 0), TW'($urandom % 24));
        end
        step("R8", 1'b0, '0, 1'b0, '0);
        // R4: back-to-back replacements then idle pulse end
        for (int i = 0; i < N + 4; i++) step("R4", 1'b0, '0, 1'b1, TW'(500 + i));
        step("R4", 1'b0, '0, 1'b0, '0);
        step("R4", 1'b0, '0, 1'b0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule